// File: doc/BRIEF.md
# cSHAKE Prefix Encoder

This block assembles the encoded prefix that a cSHAKE or KMAC computation absorbs ahead of the message. It takes a function-name string N and a customization string S. Each string arrives as a byte count plus its payload bytes streamed in order. The block writes each string's length in bits as a left encoding. A count byte comes first, then the length bytes with the most significant first. After each length it places that string's payload. It concatenates N and S and packs the result little-endian into an image of eleven 32-bit words, which it exposes as one flat read-only vector.

The host pulses a start request with both lengths and a mode bit. It then streams N's bytes followed by S's bytes under a valid/ready handshake, and waits for a one-cycle completion pulse. In KMAC mode the block substitutes the fixed four-byte name "KMAC" for N, so the stream carries only S. A request whose encoded total would not fit the image is refused at once with an error pulse. The block builds the new image in a private work buffer, so the visible image changes only at the moment of completion.

Top module: `cshake_prefix_enc`

## Requirements
- R1: After reset the whole prefix image reads zero and done_o, err_o, busy_o and byte_ready_o are low.
- R2: A string of L bytes has its length encoded as L*8 bits. If L*8 is at most 255, the encoding is count byte 0x01 followed by one length byte. Otherwise it is count byte 0x02 followed by the high and then the low byte of L*8.
- R3: A string of length zero encodes as exactly the two bytes 0x01, 0x00 with no payload.
- R4: The image holds encoded N, then N's payload, then encoded S, then S's payload, with no gap. The payload bytes are taken in stream order, N's bytes first and then S's.
- R5: Image byte k sits at prefix_o[8k+7:8k], so word w occupies prefix_o[32w+31:32w] and holds bytes 4w..4w+3 with the lowest-numbered byte in bits [7:0].
- R6: With kmac_mode_i high, n_len_i is ignored and N is "KMAC". Word 0 is then 0x4D4B2001 and the low half of word 1 is 0x4341; with an empty S, word 1 is 0x00014341.
- R7: Image bytes beyond the encoded total are zero, even when an earlier image was longer.
- R8: A start whose encoded total exceeds 44 bytes raises err_o for one cycle in the next cycle. It never sets busy_o and leaves the image unchanged. A total of exactly 44 bytes is accepted.
- R9: done_o is a single-cycle pulse, and the image changes only in the cycle done_o is high.
- R10: A start request while busy_o is high has no effect on the image being built.
- R11: byte_ready_o is high only while a streamed payload byte is expected. It is low during length bytes and during KMAC's fixed name, and a byte is taken only when byte_valid_i and byte_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| kmac_mode_i | input | 1 | Force N to "KMAC" |
| n_len_i | input | LEN_W | Byte length of N |
| s_len_i | input | LEN_W | Byte length of S |
| byte_valid_i | input | 1 | Payload byte valid |
| byte_data_i | input | 8 | Payload byte |
| byte_ready_o | output | 1 | Block accepts a payload byte |
| busy_o | output | 1 | Encoding in progress |
| done_o | output | 1 | One-cycle pulse: new image visible |
| err_o | output | 1 | One-cycle pulse: request refused as oversize |
| prefix_o | output | NUM_WORDS*32 | Packed prefix image |

## Verification
The bench builds the block with its default parameters: eleven words (a 44-byte image) and a 6-bit length field allowing strings of up to 63 bytes. That length range reaches both sides of the one-to-two length-byte switch, at 31 and 32 bytes. It also reaches requests that land exactly on the 44-byte limit and just past it. KMAC mode with a 39-byte S overflows only because of the fixed name, which exercises the size check with the substituted N length.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HDR    = 2'd1,
    ST_DATA   = 2'd2,
    ST_COMMIT = 2'd3
  } cpe_state_e;

  // Encoded size in bytes of a string of len bytes.
  function automatic int unsigned enc_bytes(int unsigned len);
    return (len * 8 <= 255) ? len + 2 : len + 3;
  endfunction

  // Fixed function name used in KMAC mode.
  function automatic logic [7:0] kmac_name_byte(logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h4B;
      2'd1:    return 8'h4D;
      2'd2:    return 8'h41;
      default: return 8'h43;
    endcase
  endfunction

endpackage

// File: rtl/cpe_len_enc.sv
module cpe_len_enc #(
  parameter int LEN_W = 6
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [1:0]       hdr_cnt_o,
  output logic [2:0][7:0]  hdr_o
);
  logic [15:0] bits;
  assign bits = 16'(len_i) << 3;

  always_comb begin
    if (bits[15:8] == 8'h00) begin
      hdr_cnt_o = 2'd2;
      hdr_o[0]  = 8'h01;
      hdr_o[1]  = bits[7:0];
      hdr_o[2]  = 8'h00;
    end else begin
      hdr_cnt_o = 2'd3;
      hdr_o[0]  = 8'h02;
      hdr_o[1]  = bits[15:8];
      hdr_o[2]  = bits[7:0];
    end
  end
endmodule

// File: rtl/cpe_seq.sv
module cpe_seq
  import cpe_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int MAX_BYTES = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             kmac_mode_i,
  input  logic [LEN_W-1:0] n_len_i,
  input  logic [LEN_W-1:0] s_len_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_data_i,
  input  logic [1:0]       hdr_cnt_i,
  input  logic [2:0][7:0]  hdr_i,
  output logic [LEN_W-1:0] cur_len_o,
  output logic             byte_ready_o,
  output logic             clear_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_byte_o,
  output logic             commit_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [LEN_W-1:0] KMAC_LEN = LEN_W'(4);

  cpe_state_e       state_q, state_n;
  logic             sel_q, sel_n, kmac_q, kmac_n;
  logic [LEN_W-1:0] nlen_q, nlen_n, slen_q, slen_n, idx_q, idx_n;
  logic             err_n, const_src, take;
  logic [LEN_W-1:0] eff_n;
  logic [7:0]       hdr_byte;

  assign cur_len_o = sel_q ? slen_q : nlen_q;
  assign const_src = !sel_q && kmac_q;
  assign eff_n     = kmac_mode_i ? KMAC_LEN : n_len_i;
  assign busy_o    = (state_q != ST_IDLE);

  always_comb begin
    case (idx_q[1:0])
      2'd0:    hdr_byte = hdr_i[0];
      2'd1:    hdr_byte = hdr_i[1];
      default: hdr_byte = hdr_i[2];
    endcase
  end

  always_comb begin
    state_n = state_q; sel_n = sel_q; kmac_n = kmac_q;
    nlen_n = nlen_q; slen_n = slen_q; idx_n = idx_q;
    err_n = 1'b0; clear_o = 1'b0; wr_en_o = 1'b0; wr_byte_o = 8'h00;
    commit_o = 1'b0; byte_ready_o = 1'b0; take = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (enc_bytes(32'(eff_n)) + enc_bytes(32'(s_len_i)) > MAX_BYTES) begin
            err_n = 1'b1;
          end else begin
            clear_o = 1'b1;
            kmac_n  = kmac_mode_i;
            nlen_n  = eff_n;
            slen_n  = s_len_i;
            sel_n   = 1'b0;
            idx_n   = '0;
            state_n = ST_HDR;
          end
        end
      end
      ST_HDR: begin
        wr_en_o   = 1'b1;
        wr_byte_o = hdr_byte;
        if (idx_q == LEN_W'(hdr_cnt_i - 2'd1)) begin
          idx_n = '0;
          if (cur_len_o != '0) state_n = ST_DATA;
          else if (!sel_q)     sel_n = 1'b1;
          else                 state_n = ST_COMMIT;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      ST_DATA: begin
        byte_ready_o = !const_src;
        take         = const_src || byte_valid_i;
        wr_en_o      = take;
        wr_byte_o    = const_src ? kmac_name_byte(idx_q[1:0]) : byte_data_i;
        if (take) begin
          if (idx_q == cur_len_o - 1'b1) begin
            idx_n = '0;
            if (!sel_q) begin
              sel_n   = 1'b1;
              state_n = ST_HDR;
            end else begin
              state_n = ST_COMMIT;
            end
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      default: begin
        commit_o = 1'b1;
        state_n  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      kmac_q  <= 1'b0;
      nlen_q  <= '0;
      slen_q  <= '0;
      idx_q   <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_n;
      sel_q   <= sel_n;
      kmac_q  <= kmac_n;
      nlen_q  <= nlen_n;
      slen_q  <= slen_n;
      idx_q   <= idx_n;
      done_o  <= commit_o;
      err_o   <= err_n;
    end
  end
endmodule

// File: rtl/cpe_image.sv
module cpe_image #(
  parameter int MAX_BYTES = 44
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     wr_en_i,
  input  logic [7:0]               wr_byte_i,
  input  logic                     commit_i,
  output logic [MAX_BYTES*8-1:0]   image_o
);
  localparam int PTR_W = $clog2(MAX_BYTES + 1);

  logic [PTR_W-1:0]                ptr_q;
  logic [MAX_BYTES-1:0][7:0]       work_q;
  logic [MAX_BYTES-1:0][7:0]       img_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (wr_en_i) ptr_q <= ptr_q + 1'b1;
  end

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   work_q[b] <= 8'h00;
      else if (clear_i)                             work_q[b] <= 8'h00;
      else if (wr_en_i && ptr_q == PTR_W'(b))       work_q[b] <= wr_byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        img_q <= '0;
    else if (commit_i) img_q <= work_q;
  end

  assign image_o = img_q;
endmodule

// File: rtl/cshake_prefix_enc.sv
module cshake_prefix_enc #(
  parameter int NUM_WORDS = 11,
  parameter int LEN_W     = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   kmac_mode_i,
  input  logic [LEN_W-1:0]       n_len_i,
  input  logic [LEN_W-1:0]       s_len_i,
  input  logic                   byte_valid_i,
  input  logic [7:0]             byte_data_i,
  output logic                   byte_ready_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [NUM_WORDS*32-1:0] prefix_o
);
  localparam int MAX_BYTES = NUM_WORDS * 4;

  logic [LEN_W-1:0] cur_len;
  logic [1:0]       hdr_cnt;
  logic [2:0][7:0]  hdr;
  logic             clear, wr_en, commit;
  logic [7:0]       wr_byte;

  cpe_len_enc #(.LEN_W(LEN_W)) u_len_enc (
    .len_i(cur_len), .hdr_cnt_o(hdr_cnt), .hdr_o(hdr)
  );

  cpe_seq #(.LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kmac_mode_i(kmac_mode_i),
    .n_len_i(n_len_i), .s_len_i(s_len_i), .byte_valid_i(byte_valid_i),
    .byte_data_i(byte_data_i), .hdr_cnt_i(hdr_cnt), .hdr_i(hdr),
    .cur_len_o(cur_len), .byte_ready_o(byte_ready_o), .clear_o(clear),
    .wr_en_o(wr_en), .wr_byte_o(wr_byte), .commit_o(commit),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  cpe_image #(.MAX_BYTES(MAX_BYTES)) u_image (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .wr_en_i(wr_en),
    .wr_byte_i(wr_byte), .commit_i(commit), .image_o(prefix_o)
  );
endmodule

// File: rtl/cshake_prefix_enc_chk.sv
module cshake_prefix_enc_chk #(
  parameter int NUM_WORDS = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    byte_ready_o,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    err_o,
  input logic [NUM_WORDS*32-1:0] prefix_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                   // R9
  AST_IMAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(prefix_o));                        // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));                             // R9
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);                                    // R8
  AST_ERR_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && done_o));                                   // R8
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> busy_o);                              // R11
endmodule

bind cshake_prefix_enc cshake_prefix_enc_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_ready_o(byte_ready_o), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .prefix_o(prefix_o)
);

// File: tb/cshake_prefix_enc_bench.sv
module cshake_prefix_enc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 11;
  localparam int NB = NW * 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, kmac_mode_i = 1'b0, byte_valid_i = 1'b0;
  logic [5:0] n_len_i = '0, s_len_i = '0;
  logic [7:0] byte_data_i = '0;
  logic byte_ready_o, busy_o, done_o, err_o;
  logic [NW*32-1:0] prefix_o;

  int checks = 0, fails = 0;
  logic [7:0] stream [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  cshake_prefix_enc u_cshake_prefix_enc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kmac_mode_i(kmac_mode_i),
    .n_len_i(n_len_i), .s_len_i(s_len_i), .byte_valid_i(byte_valid_i),
    .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .prefix_o(prefix_o)
  );

  task automatic check(bit ok, string req, string what, logic [NW*32-1:0] act, logic [NW*32-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] kname(int i);
    case (i) 0: return 8'h4B; 1: return 8'h4D; 2: return 8'h41; default: return 8'h43; endcase
  endfunction

  function automatic logic [NW*32-1:0] model(bit kmac, int nlen, int slen);
    logic [NW*32-1:0] v = '0;
    int p = 0, k = 0, len, bits;
    for (int s = 0; s < 2; s++) begin
      len  = (s == 0) ? (kmac ? 4 : nlen) : slen;
      bits = len * 8;
      if (bits <= 255) begin
        v[8*p +: 8] = 8'h01; p++;
        v[8*p +: 8] = bits[7:0]; p++;
      end else begin
        v[8*p +: 8] = 8'h02; p++;
        v[8*p +: 8] = bits[15:8]; p++;
        v[8*p +: 8] = bits[7:0]; p++;
      end
      for (int i = 0; i < len; i++) begin
        if (s == 0 && kmac) v[8*p +: 8] = kname(i);
        else begin v[8*p +: 8] = stream[k]; k++; end
        p++;
      end
    end
    return v;
  endfunction

  // One accepted operation; checks image, done pulse, ready in header.
  task automatic run_op(bit kmac, int nlen, int slen, int seed, bit gaps, bit busy_start, string req);
    int total = (kmac ? 0 : nlen) + slen;
    int k = 0, cyc = 0, dones = 0;
    logic [NW*32-1:0] exp;
    for (int i = 0; i < total; i++) stream[i] = 8'((seed + i * 37 + 5) ^ (i >> 1));
    exp = model(kmac, nlen, slen);
    @(negedge clk);
    start_i = 1'b1; kmac_mode_i = kmac; n_len_i = 6'(nlen); s_len_i = 6'(slen);
    @(negedge clk);
    start_i = 1'b0;
    check(byte_ready_o == 1'b0 && busy_o == 1'b1, "R11", "ready low in header", {351'b0, byte_ready_o}, '0);
    while (dones == 0 && cyc < 2000) begin
      if (done_o) dones++;
      else begin
        start_i = (busy_start && cyc == 3);
        if (busy_start && cyc == 3) begin
          kmac_mode_i = ~kmac; n_len_i = 6'd1; s_len_i = 6'd1;
        end
        byte_valid_i = (k < total) && !(gaps && (cyc % 3 == 1));
        byte_data_i  = stream[k];
        if (byte_valid_i && byte_ready_o) k++;
        cyc++;
        @(negedge clk);
      end
    end
    byte_valid_i = 1'b0; start_i = 1'b0;
    check(dones == 1, "R9", "done seen", NW*32'(dones), 1);
    check(prefix_o == exp, req, "image", prefix_o, exp);
    @(negedge clk);
    check(done_o == 1'b0 && busy_o == 1'b0, "R9", "done single pulse", {350'b0, done_o, busy_o}, '0);
    check(prefix_o == exp, "R10", "image stable after done", prefix_o, exp);
  endtask

  task automatic run_err(bit kmac, int nlen, int slen);
    logic [NW*32-1:0] prev = prefix_o;
    @(negedge clk);
    start_i = 1'b1; kmac_mode_i = kmac; n_len_i = 6'(nlen); s_len_i = 6'(slen);
    @(negedge clk);
    start_i = 1'b0;
    check(err_o == 1'b1 && busy_o == 1'b0, "R8", "error pulse", {350'b0, err_o, busy_o}, 2);
    @(negedge clk);
    check(err_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R8", "error clears", {349'b0, err_o, busy_o, done_o}, '0);
    check(prefix_o == prev, "R8", "image unchanged", prefix_o, prev);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NW*32-1:0] e;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(prefix_o == '0 && !done_o && !err_o && !busy_o && !byte_ready_o, "R1", "reset state", prefix_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 KMAC, empty S (R3)
    run_op(1'b1, 9, 0, 1, 1'b0, 1'b0, "R6");
    check(prefix_o[31:0] == 32'h4D4B2001 && prefix_o[63:32] == 32'h00014341, "R6", "fixed words",
          prefix_o, {288'b0, 32'h00014341, 32'h4D4B2001});
    // R6 KMAC, two-byte S
    run_op(1'b1, 0, 2, 9, 1'b1, 1'b0, "R6");
    check(prefix_o[47:32] == 16'h4341 && prefix_o[63:48] == 16'h1001, "R6", "word1 with S", prefix_o[63:32], 0);
    // R3 and R7: both empty after longer image
    run_op(1'b0, 0, 0, 3, 1'b0, 1'b0, "R3");
    e = '0; e[31:0] = 32'h00010001;
    check(prefix_o == e, "R7", "trailing zero", prefix_o, e);
    // R2, R4, R5, R11: one length byte, stalls
    run_op(1'b0, 3, 31, 20, 1'b1, 1'b0, "R4");
    check(prefix_o[39:0] == {stream[2], stream[1], stream[0], 8'h18, 8'h01}, "R5", "byte lanes",
          prefix_o[39:0], {stream[2], stream[1], stream[0], 8'h18, 8'h01});
    // R2: two length bytes
    run_op(1'b0, 3, 32, 40, 1'b0, 1'b0, "R2");
    check(prefix_o[63:40] == 24'h000102, "R2", "two-byte length", prefix_o[63:40], 24'h000102);
    // R8 boundary: exactly 44 bytes accepted
    run_op(1'b0, 0, 39, 60, 1'b1, 1'b0, "R8");
    // R8 oversize refused
    run_err(1'b0, 0, 40);
    run_err(1'b1, 0, 39);
    // R10 start while busy ignored
    run_op(1'b0, 5, 5, 77, 1'b0, 1'b1, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule